// File: doc/BRIEF.md
# MDIO Management Command Controller

This block runs one Clause-22 PHY management transaction for each command a host writes. The host writes a single 32-bit command word that holds the operation, the PHY and register addresses and, for a write, the 16-bit payload. The block then drives a complete management frame on MDC and MDIO. MDIO is tri-stated through a separate output enable. The same word, read back, shows a busy flag. Hardware clears that flag when the frame ends. After a read, the word also holds the value returned by the PHY.

MDC is produced by dividing the system clock and stays low whenever no frame is in progress. The host launches a command and then polls the busy flag. The frame always has a fixed length, so the flag always clears after the same number of cycles.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset, the command register reads 0, MDC is low and the MDIO output enable is low.
- R2: A command write with bit 29 set, made while idle, starts a frame. Bit 29 then reads 1 for exactly 128*HALF_DIV clock cycles and is cleared by hardware.
- R3: A write frame puts these 64 bits on the MDIO output, with the output enable high throughout: 32 ones, then 01, then opcode 01, then the PHY address (bits 25:21), then the register address (bits 20:16), then turnaround 10, then data bits 15:0, MSB first. MDIO changes only while MDC is low.
- R4: A read frame uses opcode 10. The output enable goes low at the turnaround (frame bit 46) and stays low until the frame ends.
- R5: In a read, MDIO input is sampled on the MDC rising edges of frame bits 48 to 63, MSB first. When busy clears, the sampled value appears in bits 15:0, and bits 27:16 keep the values that were written.
- R6: MDC is low for HALF_DIV cycles and high for HALF_DIV cycles in every bit period, and stays low while idle.
- R7: A command write made while busy is set has no effect: the frame in progress, its result and the register contents are unchanged, and no second frame follows.
- R8: A command write with bit 29 clear stores bits 27:0 (visible on readback) without starting a frame.
- R9: Bit 27 set selects a read frame, even if bit 26 is also set. With bit 27 clear, the frame is a write. Bits 31:30 and 28 always read 0.
- R10: Busy never stays set for more than 128*HALF_DIV consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command register readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest case to reach is a command write that lands in the middle of a frame. It must leave the serial stream, the captured read data and the stored fields untouched, and it must not start a second frame afterwards. The bench issues a read, and about a hundred cycles later, while the PHY model is still being clocked, it writes a different command with the start bit set. The scoreboard keeps comparing every MDC rising edge against the first frame. The final register value is checked against the first command and its response. Any extra MDC edge after the frame ends fails because the expected queue is then empty.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int START_BIT = 29;
  localparam int RD_BIT    = 27;
  localparam int WR_BIT    = 26;
  localparam int PHY_LSB   = 21;
  localparam int REG_LSB   = 16;
  localparam int FRAME_BITS = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = 48;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic mdio_cmd_t decode_word(input logic [27:0] w);
    mdio_cmd_t c;
    c.rd    = w[RD_BIT];
    c.wr    = w[WR_BIT];
    c.phy   = w[PHY_LSB +: 5];
    c.regad = w[REG_LSB +: 5];
    c.data  = w[15:0];
    return c;
  endfunction

  function automatic logic [31:0] pack_word(input logic busy, input mdio_cmd_t c);
    return {2'b00, busy, 1'b0, c.rd, c.wr, c.phy, c.regad, c.data};
  endfunction

  // Full 64-bit frame image, transmitted from bit 63 downward.
  function automatic logic [FRAME_BITS-1:0] build_frame(input logic is_rd, input logic [4:0] phy,
                                                        input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, ra,
            (is_rd ? 2'b11 : 2'b10), (is_rd ? 16'hFFFF : d)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  p_mdc_edge_on_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mdc));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  mdio_cmd_t   new_cmd,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_value,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [FRAME_BITS-1:0] frame;
  logic [5:0]            bitcnt;
  logic                  rd_mode;
  logic [15:0]           shift;

  assign done     = busy && fall_evt && (bitcnt == 6'(FRAME_BITS - 1));
  assign rd_value = shift;
  assign mdio_o   = busy ? frame[~bitcnt] : 1'b1;
  assign mdio_oe  = busy && !(rd_mode && (bitcnt >= 6'(TA_IDX)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bitcnt  <= '0;
      frame   <= '1;
      rd_mode <= 1'b0;
      shift   <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      bitcnt  <= '0;
      rd_mode <= new_cmd.rd;
      frame   <= build_frame(new_cmd.rd, new_cmd.phy, new_cmd.regad, new_cmd.data);
      shift   <= '0;
    end else if (busy) begin
      if (rise_evt && rd_mode && (bitcnt >= 6'(DATA_IDX)))
        shift <= {shift[14:0], mdio_i};
      if (fall_evt) begin
        if (done) busy <= 1'b0;
        else      bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  p_launch_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy && (bitcnt == 6'd0));
  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_release_at_ta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mdio_oe)) |-> (rd_mode && bitcnt == 6'(TA_IDX)));
endmodule

// File: rtl/mdio_cmdreg.sv
module mdio_cmdreg
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        busy,
  input  logic        done,
  input  logic [15:0] rd_value,
  output logic        launch,
  output mdio_cmd_t   new_cmd,
  output logic [31:0] cmd_rdata
);
  mdio_cmd_t stored;
  logic      accept;
  logic      unused_bits;

  assign unused_bits = ^{cmd_wdata[31:30], cmd_wdata[28]};
  assign new_cmd     = decode_word(cmd_wdata[27:0]);
  assign accept      = cmd_wr && !busy;
  assign launch      = accept && cmd_wdata[START_BIT];
  assign cmd_rdata   = pack_word(busy, stored);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored <= '0;
    end else if (accept) begin
      stored <= new_cmd;
    end else if (done && stored.rd) begin
      stored.data <= rd_value;
    end
  end

  p_ignore_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr && !done) |=> $stable(stored));
  p_no_launch_without_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !cmd_wdata[START_BIT]) |=> !busy);
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] cmd_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_CYCLES = 2 * HALF_DIV * FRAME_BITS;

  logic        busy, done, launch, rise_evt, fall_evt;
  logic [15:0] rd_value;
  mdio_cmd_t   new_cmd;

  mdio_cmdreg u_reg (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_value(rd_value),
    .launch(launch), .new_cmd(new_cmd), .cmd_rdata(cmd_rdata)
  );

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .new_cmd(new_cmd),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rd_value(rd_value),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // Busy-age counter for the bounded-busy check.
  int unsigned busy_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_age <= 0;
    else if (!busy) busy_age <= 0;
    else            busy_age <= busy_age + 1;
  end

  p_busy_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_age < FRAME_CYCLES));
  p_mdio_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && !fall_evt) |=> ($stable(mdio_o) && $stable(mdio_oe)));
  p_oe_only_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> cmd_rdata[START_BIT]);
endmodule

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
  localparam int H = 4;
  localparam int FRAME_CYC = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [1:0]  exp_q[$];
  logic [15:0] phy_resp = '0;
  bit          phy_rd = 0;
  int          rise_k = 0;

  always #2 clk = ~clk;

  mdio_ctrl #(.HALF_DIV(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected {oe, value} for frame bit k, derived from the frame layout.
  function automatic logic [1:0] exp_bit(input bit rd, input logic [4:0] phy,
                                         input logic [4:0] ra, input logic [15:0] d, input int k);
    if (k < 32)  return 2'b11;
    if (k == 32) return 2'b10;
    if (k == 33) return 2'b11;
    if (k == 34) return {1'b1, rd};
    if (k == 35) return {1'b1, !rd};
    if (k < 41)  return {1'b1, phy[40 - k]};
    if (k < 46)  return {1'b1, ra[45 - k]};
    if (rd)      return 2'b00;
    if (k == 46) return 2'b11;
    if (k == 47) return 2'b10;
    return {1'b1, d[63 - k]};
  endfunction

  // Monitor: pops one expected item at every MDC rising edge, checks half-period widths.
  initial begin
    int cyc = 0;
    int last_chg = 0;
    logic prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && mdc !== prev) begin
        if (mdc) begin
          if (rise_k > 0)
            check(cyc - last_chg == H, "R6", "MDC low width", cyc - last_chg, H);
          if (exp_q.size() == 0) begin
            check(0, "R7", "unexpected MDC rise", 1, 0);
          end else begin
            logic [1:0] e;
            e = exp_q.pop_front();
            check(mdio_oe === e[1], phy_rd ? "R4" : "R3",
                  $sformatf("oe at bit %0d", rise_k), mdio_oe, e[1]);
            if (e[1])
              check(mdio_o === e[0], "R3", $sformatf("mdio at bit %0d", rise_k), mdio_o, e[0]);
          end
          rise_k++;
          if (rise_k >= 48 && rise_k < 64) mdio_i = phy_resp[63 - rise_k];
          else mdio_i = 1'b1;
        end else begin
          check(cyc - last_chg == H, "R6", "MDC high width", cyc - last_chg, H);
        end
        last_chg = cyc;
      end
      prev = mdc;
    end
  end

  // Driver: push the expected frame, write the command, time busy, check result.
  task automatic run_cmd(input logic [31:0] word, input logic [15:0] resp,
                         input bit intrude, input logic [31:0] other);
    bit rd;
    int n;
    logic [31:0] exp_reg;
    rd = word[27];
    for (int k = 0; k < 64; k++)
      exp_q.push_back(exp_bit(rd, word[25:21], word[20:16], word[15:0], k));
    phy_resp = resp;
    phy_rd = rd;
    rise_k = 0;
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = word;
    @(negedge clk);
    cmd_wr = 1'b0;
    n = 0;
    while (cmd_rdata[29] && n < 4 * FRAME_CYC) begin
      n++;
      if (intrude && n == 100) begin
        cmd_wr = 1'b1;
        cmd_wdata = other;
      end else begin
        cmd_wr = 1'b0;
      end
      @(negedge clk);
    end
    cmd_wr = 1'b0;
    check(n == FRAME_CYC, "R2", "busy duration", n, FRAME_CYC);
    exp_reg = {4'b0000, word[27:16], rd ? resp : word[15:0]};
    check(cmd_rdata === exp_reg, rd ? "R5" : "R2", "register after frame", cmd_rdata, exp_reg);
    check(exp_q.size() == 0, "R3", "frame bits left", exp_q.size(), 0);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R6", "idle mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_rdata === 32'h0, "R1", "reset register", cmd_rdata, 0);
    check(mdc === 1'b0, "R1", "reset mdc", mdc, 0);
    check(mdio_oe === 1'b0, "R1", "reset oe", mdio_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: plain write frame
    run_cmd({2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'h15, 5'h0A, 16'hA5C3}, 16'h0, 0, 0);
    // R4 R5: read frame
    run_cmd({2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 5'h01, 5'h02, 16'h0000}, 16'h3C96, 0, 0);
    // R9: both op bits set -> read; reserved bits written as 1 read back 0
    run_cmd({2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 5'h1F, 5'h00, 16'h1234}, 16'h8001, 0, 0);
    // R9: no op bit -> write frame
    run_cmd({2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 5'h00, 5'h1F, 16'hFFFF}, 16'h0, 0, 0);

    // R8: store without start
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = {4'b0000, 1'b1, 1'b0, 5'h0C, 5'h13, 16'h5A5A};
    @(negedge clk);
    cmd_wr = 1'b0;
    check(cmd_rdata === {4'b0000, 1'b1, 1'b0, 5'h0C, 5'h13, 16'h5A5A}, "R8",
          "stored without start", cmd_rdata, {4'b0000, 1'b1, 1'b0, 5'h0C, 5'h13, 16'h5A5A});
    repeat (40) @(negedge clk);
    check(mdc === 1'b0 && cmd_rdata[29] === 1'b0, "R8", "no frame started",
          {mdc, cmd_rdata[29]}, 0);

    // R7: intruding write mid-read
    run_cmd({2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 5'h07, 5'h11, 16'h0000}, 16'hC0DE, 1,
            {2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'h1A, 5'h05, 16'h9999});
    repeat (3 * 2 * H) @(negedge clk);
    check(mdc === 1'b0 && cmd_rdata[29] === 1'b0, "R7", "no second frame",
          {mdc, cmd_rdata[29]}, 0);

    // R2: back-to-back commands
    run_cmd({2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 5'h03, 5'h04, 16'h0F0F}, 16'h0, 0, 0);
    run_cmd({2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 5'h03, 5'h04, 16'h0000}, 16'h7E81, 0, 0);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule